// File: doc/BRIEF.md
# I2C Register-Pointer Slave

This block is an I2C slave that exposes a bank of 8-bit registers to a bus master. It watches SCL and SDA, detects START, repeated START and STOP, and answers to one fixed 7-bit device address. The first byte after the address in a write is a command byte that sets an internal register pointer. Later data bytes in the same write are stored at the pointer, which advances after each byte and wraps around the bank.

To read, the master writes the address and a command byte, issues a repeated START, and sends the address again with the direction bit set. The slave then returns registers starting at the pointer. The master acknowledges each byte it wants to continue and refuses the last one before STOP. The pointer survives STOP, so a later read with no command byte resumes where the last access left off.

SDA is open-drain. The block only ever pulls the line low, and the pad logic turns `sda_oe_o` into a low drive. Both bus lines pass through two-flop synchronizers, so the system clock must run at least eight times faster than SCL. The lowest `N_RO` registers are read-only and mirror `ro_data_i`. The rest are plain storage, shown on `reg_q_o`.

Top module: `i2c_reg_slave`

## Requirements
- R1: The slave ACKs (pulls SDA low in the ninth clock) only the address byte whose upper seven bits equal 7'b1100100. Bit 0 is the direction: 0 means write, 1 means read. On any other address it NAKs and ignores every later byte and never drives SDA until the next START or STOP.
- R2: A falling SDA with SCL high (START or repeated START) restarts the address phase from any state. A rising SDA with SCL high (STOP) returns the slave to idle.
- R3: In a write, the byte after a matched address is ACKed and its low four bits load the register pointer.
- R4: Each further write byte is ACKed and stored at the pointer. The pointer then increments modulo 16, so a burst fills consecutive registers and wraps from 15 to 0.
- R5: Registers 0 and 1 are read-only. Writes to them are ACKed and discarded, and reads return ro_data_i[7:0] for register 0 and ro_data_i[15:8] for register 1.
- R6: After a matched address with the direction bit at 1, the slave sends the register at the pointer MSB first, one bit per SCL clock. On a master ACK the pointer increments and the next register follows.
- R7: On a master NAK the slave releases SDA and sends nothing more until START or STOP. The pointer is not incremented.
- R8: The pointer keeps its value across STOP. A read started without a command byte begins at the kept pointer.
- R9: The slave changes its SDA drive only while SCL is low.
- R10: After reset, SDA is released, all writable registers read zero and the pointer is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock, at least 8x SCL |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe_o | output | 1 | 1 pulls SDA low; 0 releases it |
| ro_data_i | input | N_RO*8 | Contents of the read-only registers, register 0 in the low byte |
| reg_q_o | output | (N_REGS-N_RO)*8 | Writable registers, register N_RO in the low byte |

## Verification
On the eighth rising SCL edge of a data byte, the register write and the pointer increment happen in the same cycle, and in a burst the wrap from 15 to 0 can land on a read-only entry at that moment. A sixteen-byte burst that starts at register 2 forces the wrap and the discarded writes into one transaction. The result is judged through `reg_q_o` and by reading the whole bank back from every start pointer. A read restart, where the master ACK advances the pointer just before the next byte is loaded, is covered by the same read-back sweep.

// File: rtl/i2c_reg_pkg.sv
package i2c_reg_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_RX_DONE,
    ST_ACK_TX,
    ST_TX,
    ST_ACK_RX,
    ST_IGNORE
  } bus_state_e;

  typedef enum logic [1:0] {
    BK_ADDR,
    BK_CMD,
    BK_DATA
  } byte_kind_e;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int unsigned N_LINES = 2,
  parameter int unsigned STAGES  = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_LINES-1:0] line_i,
  output logic [N_LINES-1:0] level_o,
  output logic [N_LINES-1:0] rise_o,
  output logic [N_LINES-1:0] fall_o
);
  for (genvar g = 0; g < N_LINES; g++) begin : g_line
    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        chain_q <= '1;
        prev_q  <= 1'b1;
      end else begin
        chain_q <= {chain_q[STAGES-2:0], line_i[g]};
        prev_q  <= chain_q[STAGES-1];
      end
    end

    assign level_o[g] = chain_q[STAGES-1];
    assign rise_o[g]  = chain_q[STAGES-1] & ~prev_q;
    assign fall_o[g]  = ~chain_q[STAGES-1] & prev_q;
  end
endmodule

// File: rtl/i2c_reg_bank.sv
module i2c_reg_bank #(
  parameter int unsigned N_REGS = 16,
  parameter int unsigned N_RO   = 2,
  parameter int unsigned DW     = 8,
  localparam int unsigned AW    = $clog2(N_REGS),
  localparam int unsigned N_WR  = N_REGS - N_RO
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_i,
  input  logic [AW-1:0]      addr_i,
  input  logic [DW-1:0]      wdata_i,
  input  logic [N_RO*DW-1:0] ro_data_i,
  output logic [DW-1:0]      rdata_o,
  output logic [N_WR*DW-1:0] reg_q_o
);
  logic [DW-1:0] mem [N_REGS];

  for (genvar i = 0; i < N_REGS; i++) begin : g_entry
    if (i < N_RO) begin : g_ro
      assign mem[i] = ro_data_i[i*DW +: DW];
    end else begin : g_rw
      logic [DW-1:0] q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                             q <= '0;
        else if (we_i && addr_i == AW'(i))       q <= wdata_i;
      end
      assign mem[i] = q;
      assign reg_q_o[(i-N_RO)*DW +: DW] = q;
    end
  end

  assign rdata_o = mem[addr_i];

  AST_RO_DISCARD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && 32'(addr_i) < N_RO) |=> $stable(reg_q_o)); // R5
endmodule

// File: rtl/i2c_bus_engine.sv
module i2c_bus_engine
  import i2c_reg_pkg::*;
#(
  parameter logic [6:0]  DEV_ADDR = 7'b1100100,
  parameter int unsigned PTR_W    = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             scl_lvl_i,
  input  logic             scl_rise_i,
  input  logic             scl_fall_i,
  input  logic             sda_lvl_i,
  input  logic             sda_rise_i,
  input  logic             sda_fall_i,
  input  logic [7:0]       rd_data_i,
  output logic [PTR_W-1:0] ptr_o,
  output logic             wr_en_o,
  output logic [7:0]       wr_data_o,
  output logic             sda_oe_o
);
  bus_state_e       state_q;
  byte_kind_e       kind_q;
  logic [2:0]       cnt_q;
  logic [7:0]       sr_q;
  logic [PTR_W-1:0] ptr_q;
  logic             match_q, rw_q, mack_q, sda_oe_q;
  logic             start_det, stop_det, last_bit;
  logic [7:0]       byte_nx;

  // SCL must be steadily high, not just rising, for a bus condition
  assign start_det = sda_fall_i & scl_lvl_i & ~scl_rise_i;
  assign stop_det  = sda_rise_i & scl_lvl_i & ~scl_rise_i;
  assign byte_nx   = {sr_q[6:0], sda_lvl_i};
  assign last_bit  = (state_q == ST_RX) && scl_rise_i && (cnt_q == 3'd7);

  assign wr_en_o   = last_bit && (kind_q == BK_DATA) && !start_det && !stop_det;
  assign wr_data_o = byte_nx;
  assign ptr_o     = ptr_q;
  assign sda_oe_o  = sda_oe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      kind_q   <= BK_ADDR;
      cnt_q    <= '0;
      sr_q     <= '0;
      ptr_q    <= '0;
      match_q  <= 1'b0;
      rw_q     <= 1'b0;
      mack_q   <= 1'b0;
      sda_oe_q <= 1'b0;
    end else if (start_det) begin
      state_q  <= ST_RX;
      kind_q   <= BK_ADDR;
      cnt_q    <= '0;
      sda_oe_q <= 1'b0;
    end else if (stop_det) begin
      state_q  <= ST_IDLE;
      sda_oe_q <= 1'b0;
    end else begin
      unique case (state_q)
        ST_RX: if (scl_rise_i) begin
          sr_q  <= byte_nx;
          cnt_q <= cnt_q + 3'd1;
          if (cnt_q == 3'd7) begin
            state_q <= ST_RX_DONE;
            unique case (kind_q)
              BK_ADDR: begin
                match_q <= (byte_nx[7:1] == DEV_ADDR);
                rw_q    <= byte_nx[0];
              end
              BK_CMD:  ptr_q <= byte_nx[PTR_W-1:0];
              default: ptr_q <= ptr_q + 1'b1;
            endcase
          end
        end
        ST_RX_DONE: if (scl_fall_i) begin
          if (kind_q != BK_ADDR || match_q) begin
            sda_oe_q <= 1'b1;
            state_q  <= ST_ACK_TX;
          end else begin
            state_q  <= ST_IGNORE;
          end
        end
        ST_ACK_TX: if (scl_fall_i) begin
          cnt_q <= '0;
          if (kind_q == BK_ADDR && rw_q) begin
            state_q  <= ST_TX;
            sr_q     <= rd_data_i;
            sda_oe_q <= ~rd_data_i[7];
          end else begin
            state_q  <= ST_RX;
            sda_oe_q <= 1'b0;
            kind_q   <= (kind_q == BK_ADDR) ? BK_CMD : BK_DATA;
          end
        end
        ST_TX: if (scl_fall_i) begin
          if (cnt_q == 3'd7) begin
            sda_oe_q <= 1'b0;
            state_q  <= ST_ACK_RX;
          end else begin
            cnt_q    <= cnt_q + 3'd1;
            sr_q     <= {sr_q[6:0], 1'b0};
            sda_oe_q <= ~sr_q[6];
          end
        end
        ST_ACK_RX: begin
          if (scl_rise_i) begin
            mack_q <= ~sda_lvl_i;
            if (!sda_lvl_i) ptr_q <= ptr_q + 1'b1;
          end else if (scl_fall_i) begin
            if (mack_q) begin
              state_q  <= ST_TX;
              cnt_q    <= '0;
              sr_q     <= rd_data_i;
              sda_oe_q <= ~rd_data_i[7];
            end else begin
              state_q  <= ST_IGNORE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  AST_SDA_SCL_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sda_oe_q) |-> !scl_lvl_i); // R9
  AST_IGNORE_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IGNORE) |-> !sda_oe_q); // R1
  AST_PTR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |=> ptr_q == PTR_W'($past(ptr_q) + 1'b1)); // R4
  AST_STOP_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_det |=> state_q == ST_IDLE); // R2
  AST_NAK_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ACK_RX && scl_fall_i && !scl_rise_i && !mack_q && !start_det && !stop_det)
      |=> (state_q == ST_IGNORE && !sda_oe_q)); // R7
endmodule

// File: rtl/i2c_reg_slave.sv
module i2c_reg_slave #(
  parameter logic [6:0]  DEV_ADDR = 7'b1100100,
  parameter int unsigned N_REGS   = 16,
  parameter int unsigned N_RO     = 2,
  localparam int unsigned AW      = $clog2(N_REGS),
  localparam int unsigned N_WR    = N_REGS - N_RO
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe_o,
  input  logic [N_RO*8-1:0] ro_data_i,
  output logic [N_WR*8-1:0] reg_q_o
);
  logic [1:0]    lvl, rise, fall;
  logic [AW-1:0] ptr;
  logic          wr_en;
  logic [7:0]    wr_data, rd_data;

  // line 0 = SCL, line 1 = SDA
  i2c_line_sync #(.N_LINES(2), .STAGES(2)) i_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .line_i  ({sda_i, scl_i}),
    .level_o (lvl),
    .rise_o  (rise),
    .fall_o  (fall)
  );

  i2c_bus_engine #(.DEV_ADDR(DEV_ADDR), .PTR_W(AW)) i_engine (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_lvl_i  (lvl[0]),
    .scl_rise_i (rise[0]),
    .scl_fall_i (fall[0]),
    .sda_lvl_i  (lvl[1]),
    .sda_rise_i (rise[1]),
    .sda_fall_i (fall[1]),
    .rd_data_i  (rd_data),
    .ptr_o      (ptr),
    .wr_en_o    (wr_en),
    .wr_data_o  (wr_data),
    .sda_oe_o   (sda_oe_o)
  );

  i2c_reg_bank #(.N_REGS(N_REGS), .N_RO(N_RO), .DW(8)) i_bank (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (wr_en),
    .addr_i    (ptr),
    .wdata_i   (wr_data),
    .ro_data_i (ro_data_i),
    .rdata_o   (rd_data),
    .reg_q_o   (reg_q_o)
  );
endmodule

// File: tb/test_i2c_reg_slave.sv
module test_i2c_reg_slave;
  localparam int N_REGS = 16;
  localparam int N_RO   = 2;
  localparam int Q      = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic m_sda = 1'b1;
  logic sda_oe;
  logic sda_bus;
  logic [N_RO*8-1:0] ro_data = 16'h5AA5;
  logic [(N_REGS-N_RO)*8-1:0] reg_q;
  logic [7:0] model [N_REGS];
  int checks = 0;
  int errors = 0;
  int r9_viol = 0;
  logic scl_q = 1'b1;
  logic oe_prev = 1'b0;

  always #5 clk = ~clk;

  assign sda_bus = m_sda & ~sda_oe;

  i2c_reg_slave i_i2c_reg_slave (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .scl_i     (scl),
    .sda_i     (sda_bus),
    .sda_oe_o  (sda_oe),
    .ro_data_i (ro_data),
    .reg_q_o   (reg_q)
  );

  // R9 monitor: slave drive must not move while SCL is high
  always @(posedge clk) scl_q = scl;
  always @(negedge clk) begin
    if (rst_n && sda_oe != oe_prev && scl_q) r9_viol++;
    oe_prev = sda_oe;
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; scl = 1'b1; wq();
    m_sda = 1'b0; wq();
    scl = 1'b0; wq();
  endtask

  task automatic bus_rstart();
    m_sda = 1'b1; wq();
    scl = 1'b1; wq();
    m_sda = 1'b0; wq();
    scl = 1'b0; wq();
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; wq();
    scl = 1'b1; wq();
    m_sda = 1'b1; wq();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack_bit);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; wq();
      scl = 1'b1; wq(); wq();
      scl = 1'b0;
    end
    m_sda = 1'b1; wq();
    scl = 1'b1; wq();
    ack_bit = sda_bus; wq();
    scl = 1'b0; wq();
  endtask

  task automatic recv_byte(output logic [7:0] b, input logic do_ack);
    m_sda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wq();
      scl = 1'b1; wq();
      b[i] = sda_bus; wq();
      scl = 1'b0;
    end
    m_sda = do_ack ? 1'b0 : 1'b1; wq();
    scl = 1'b1; wq(); wq();
    scl = 1'b0; wq();
    m_sda = 1'b1;
  endtask

  function automatic logic [7:0] burst_val(int k);
    return 8'((k * 37 + 11) & 8'hFF);
  endfunction

  logic ack;
  logic [7:0] rb;
  int silent;

  initial begin
    model[0] = ro_data[7:0];
    model[1] = ro_data[15:8];
    for (int i = N_RO; i < N_REGS; i++) model[i] = 8'h00;
    repeat (4) @(negedge clk);
    // R10 reset state
    chk("R10 sda released", 32'(sda_oe), 32'd0);
    chk("R10 regs zero", 32'(reg_q == '0), 32'd1);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 address sweep: every foreign address is refused
    for (int a = 0; a < 128; a++) begin
      if (a == 7'h64) continue;
      bus_start();
      send_byte({7'(a), 1'b0}, ack);
      chk("R1 foreign address NAK", 32'(ack), 32'd1);
      bus_stop();
    end

    // R1 bytes after a refused address are ignored
    bus_start();
    send_byte(8'hCA, ack); chk("R1 NAK addr 0x65", 32'(ack), 32'd1);
    send_byte(8'h05, ack); chk("R1 ignored cmd", 32'(ack), 32'd1);
    send_byte(8'hAA, ack); chk("R1 ignored data", 32'(ack), 32'd1);
    bus_stop();
    chk("R1 regs untouched", 32'(reg_q == '0), 32'd1);

    // R3 R4 R5: 16-byte burst from 2 wraps over read-only 0 and 1
    bus_start();
    send_byte(8'hC8, ack); chk("R1 own address ACK", 32'(ack), 32'd0);
    send_byte(8'h02, ack); chk("R3 command ACK", 32'(ack), 32'd0);
    for (int k = 0; k < 16; k++) begin
      send_byte(burst_val(k), ack);
      chk("R4 R5 data ACK", 32'(ack), 32'd0);
      if (((k + 2) % 16) >= N_RO) model[(k + 2) % 16] = burst_val(k);
    end
    bus_stop();
    for (int j = N_RO; j < N_REGS; j++)
      chk("R4 burst store", 32'(reg_q[(j-N_RO)*8 +: 8]), 32'(model[j]));

    // R6 R5 R7: read the whole bank from every start pointer
    for (int p = 0; p < N_REGS; p++) begin
      bus_start();
      send_byte(8'hC8, ack);
      send_byte(8'(p), ack);
      bus_rstart();
      send_byte(8'hC9, ack); chk("R1 read address ACK", 32'(ack), 32'd0);
      for (int k = 0; k < N_REGS; k++) begin
        recv_byte(rb, k != N_REGS - 1);
        chk("R6 R5 read data", 32'(rb), 32'(model[(p + k) % N_REGS]));
      end
      silent = 1;
      for (int n = 0; n < 9; n++) begin
        m_sda = 1'b1; wq();
        scl = 1'b1; wq();
        if (sda_bus !== 1'b1) silent = 0;
        wq();
        scl = 1'b0; wq();
      end
      chk("R7 silent after NAK", 32'(silent), 32'd1);
      bus_stop();
    end

    // R7 R8: pointer not advanced by NAK, kept across STOP
    bus_start();
    send_byte(8'hC9, ack);
    recv_byte(rb, 1'b0);
    chk("R7 R8 pointer after NAK", 32'(rb), 32'(model[14]));
    bus_stop();

    bus_start();
    send_byte(8'hC8, ack);
    send_byte(8'h07, ack);
    bus_stop();
    bus_start();
    send_byte(8'hC9, ack);
    recv_byte(rb, 1'b1); chk("R8 kept pointer", 32'(rb), 32'(model[7]));
    recv_byte(rb, 1'b0); chk("R6 next after ACK", 32'(rb), 32'(model[8]));
    bus_stop();

    // R2: repeated START inside a write re-enters the address phase
    bus_start();
    send_byte(8'hC8, ack);
    send_byte(8'h04, ack);
    send_byte(8'h11, ack);
    bus_rstart();
    send_byte(8'hC8, ack); chk("R2 address after rstart", 32'(ack), 32'd0);
    send_byte(8'h05, ack);
    send_byte(8'h22, ack);
    bus_stop();
    chk("R2 reg4", 32'(reg_q[(4-N_RO)*8 +: 8]), 32'h11);
    chk("R2 reg5", 32'(reg_q[(5-N_RO)*8 +: 8]), 32'h22);

    chk("R9 drive change with SCL high", 32'(r9_viol), 32'd0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule